// File: doc/BRIEF.md
# Dual-Clock Almost-Empty / Almost-Full Flag Generator

This block produces the two threshold flags of a FIFO whose write side and read side run on unrelated clocks. Each side keeps its own binary occupancy pointer, advanced by a one-cycle `push` (write clock) or `pop` (read clock) strobe. The pointer is also held in Gray code and carried across to the other side by a two-flop synchronizer. Each side then subtracts the synchronized remote pointer from its local pointer to get the fill level as that side sees it, and compares it against a programmable offset.

The almost-empty flag `ae_n` is active low and lives in the read domain. It is low while the visible fill level is at or below the offset X. The almost-full flag `af_n` is active low and lives in the write domain. It is low while the visible fill level is at or above DEPTH minus the offset Y. A local operation that moves the level into a flagged region drops that flag right after the same edge. A remote operation that moves the level out of it releases the flag only after two edges of the local clock. X is loaded in the read domain and Y in the write domain. Each comes up with a preset value after reset. The storage array, the empty and full flags and any serial offset loading lie outside this block.

Top module: `lf_level_flags`

## Requirements
- R1: After a synchronous active-low reset of a domain, that domain's pointers and synchronizer stages are zero and its offset holds its preset (PRESET_X in the read domain, PRESET_Y in the write domain). As a result `ae_n` reads 0 and `af_n` reads 1.
- R2: `ae_n` is 0 when the read-side level (synchronized write count minus local read count) is at or below X. It is 1 when that level is X+1 or more.
- R3: `af_n` is 0 when the write-side level (local write count minus synchronized read count) is at or above DEPTH−Y. It is 1 when that level is at or below DEPTH−(Y+1).
- R4: After a write that brings the level to X+1, `ae_n` is still 0 after the first following `rd_clk` rising edge. It becomes 1 after the second.
- R5: After a read that brings the level to DEPTH−(Y+1), `af_n` is still 0 after the first following `wr_clk` rising edge. It becomes 1 after the second.
- R6: A `pop` sampled on a `rd_clk` edge that takes the level down to X makes `ae_n` 0 right after that same edge.
- R7: A `push` sampled on a `wr_clk` edge that takes the level up to DEPTH−Y makes `af_n` 0 right after that same edge.
- R8: `x_ld` high on a `rd_clk` edge loads `x_val` into X, and `y_ld` high on a `wr_clk` edge loads `y_val` into Y. The affected flag reflects the new offset right after that edge.
- R9: Pointers are log2(DEPTH)+1 bits wide and wrap freely. Levels stay correct across any number of wraps, and the Gray pointer changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| push | input | 1 | One word written this write-clock cycle |
| y_ld | input | 1 | Load Y offset this write-clock cycle |
| y_val | input | log2(DEPTH) | New Y offset |
| af_n | output | 1 | Almost-full flag, active low, write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| pop | input | 1 | One word read this read-clock cycle |
| x_ld | input | 1 | Load X offset this read-clock cycle |
| x_val | input | log2(DEPTH) | New X offset |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
Directed sequences step the level one word at a time across X/X+1 and DEPTH−Y−1/DEPTH−Y. Counting clock edges after each step separates the immediate local assertion from the two-edge remote release, and a wrong synchronizer depth shows up as an off-by-one in that count. Offset reloads at a fixed level show whether the comparison follows the register. Random traffic then alternates filling and draining phases at unrelated clock rates, with occasional random offset loads, while a bench model with its own two-stage delay predicts both flags on every cycle. Because this runs for many pointer wraps, it catches both level arithmetic that ignores the wrap bit and threshold comparisons that are off by one.

// File: rtl/lf_flag_pkg.sv
// Package lf_flag_pkg
// Shared Gray-code helpers for the level-flag block. The functions work on
// 32-bit zero-extended values, so any pointer up to 32 bits may be passed
// and the result truncated by the caller.
package lf_flag_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary (prefix XOR from the MSB down).
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/lf_ptr_count.sv
// Module lf_ptr_count
// Free-running occupancy pointer for one clock domain. Advances by one on
// each cycle with step high and keeps a binary and a Gray copy in lockstep.
// The Gray copy is a register, so it can be sampled from another clock
// domain without glitches. Assumes the caller never steps past the FIFO
// capacity.
module lf_ptr_count #(
    parameter int PTR_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [PTR_W-1:0] bin_q,
    output logic [PTR_W-1:0] gray_q
);
    import lf_flag_pkg::*;

    logic [PTR_W-1:0] bin_nxt;

    // Next binary value when stepping.
    assign bin_nxt = bin_q + PTR_W'(1);

    // Pointer registers: cleared on reset, advanced together on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (step) begin
            bin_q  <= bin_nxt;
            gray_q <= PTR_W'(to_gray(32'(bin_nxt)));
        end
    end

    // R9
    gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/lf_gray_sync.sv
// Module lf_gray_sync
// Multi-stage synchronizer for a Gray-coded pointer entering this domain.
// Assumes the input changes by at most one bit between source edges, so
// every captured value is either the old or the new pointer.
module lf_gray_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: samples the remote pointer.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                // Later flops: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/lf_offset_reg.sv
// Module lf_offset_reg
// Threshold offset register. Takes its preset on reset and a new value on
// any cycle with ld high. Lives entirely in the clock domain of the flag
// that reads it.
module lf_offset_reg #(
    parameter int          W      = 10,
    parameter logic [W-1:0] PRESET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);
    // Offset storage: preset on reset, parallel load otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= PRESET;
        else if (ld) q <= val;
    end

    // R8
    offset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(val)));

endmodule

// File: rtl/lf_level_flags.sv
// Module lf_level_flags
// Almost-empty (read domain) and almost-full (write domain) flags for a
// dual-clock FIFO of DEPTH words, DEPTH a power of two. Each side counts
// its own operations, receives the other side's Gray pointer through a
// two-flop synchronizer and compares the resulting level with its offset.
// The flags are decoded from registers of their own domain only. A local
// operation therefore moves a flag right after its edge, while a remote
// one shows after SYNC_STAGES local edges.
module lf_level_flags #(
    parameter int DEPTH       = 1024,
    parameter int PRESET_X    = 8,
    parameter int PRESET_Y    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          push,
    input  logic          y_ld,
    input  logic [AW-1:0] y_val,
    output logic          af_n,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          pop,
    input  logic          x_ld,
    input  logic [AW-1:0] x_val,
    output logic          ae_n
);
    import lf_flag_pkg::*;

    localparam int PTR_W = AW + 1;
    localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);

    // Write-domain state
    logic [PTR_W-1:0] wr_bin, wr_gray;
    logic [PTR_W-1:0] rd_gray_at_wr, rd_seen;
    logic [PTR_W-1:0] wr_level, af_thr;
    logic [AW-1:0]    y_q;

    // Read-domain state
    logic [PTR_W-1:0] rd_bin, rd_gray;
    logic [PTR_W-1:0] wr_gray_at_rd, wr_seen;
    logic [PTR_W-1:0] rd_level;
    logic [AW-1:0]    x_q;

    // ---------------- write side ----------------
    lf_ptr_count #(.PTR_W(PTR_W)) i_wr_ptr (
        .clk(wr_clk), .rst_n(wr_rst_n), .step(push),
        .bin_q(wr_bin), .gray_q(wr_gray)
    );

    lf_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) i_rd2wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_at_wr)
    );

    lf_offset_reg #(.W(AW), .PRESET(AW'(PRESET_Y))) i_y_ofs (
        .clk(wr_clk), .rst_n(wr_rst_n), .ld(y_ld), .val(y_val), .q(y_q)
    );

    // Level as seen from the write side, and the almost-full boundary.
    assign rd_seen  = PTR_W'(from_gray(32'(rd_gray_at_wr)));
    assign wr_level = wr_bin - rd_seen;
    assign af_thr   = CAP - {1'b0, y_q};
    assign af_n     = (wr_level < af_thr);

    // ---------------- read side ----------------
    lf_ptr_count #(.PTR_W(PTR_W)) i_rd_ptr (
        .clk(rd_clk), .rst_n(rd_rst_n), .step(pop),
        .bin_q(rd_bin), .gray_q(rd_gray)
    );

    lf_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) i_wr2rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_at_rd)
    );

    lf_offset_reg #(.W(AW), .PRESET(AW'(PRESET_X))) i_x_ofs (
        .clk(rd_clk), .rst_n(rd_rst_n), .ld(x_ld), .val(x_val), .q(x_q)
    );

    // Level as seen from the read side, and the almost-empty decision.
    assign wr_seen  = PTR_W'(from_gray(32'(wr_gray_at_rd)));
    assign rd_level = wr_seen - rd_bin;
    assign ae_n     = (rd_level > {1'b0, x_q});

    // ---------------- checks ----------------
    // R2
    rd_level_bound_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_level <= CAP);

    // R3
    wr_level_bound_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_level <= CAP);

    // R4
    ae_release_cause_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(ae_n) |-> ((wr_seen != $past(wr_seen)) || (x_q != $past(x_q))));

    // R6
    ae_assert_cause_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $fell(ae_n) |-> ($past(pop) || (x_q != $past(x_q))));

    // R5
    af_release_cause_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(af_n) |-> ((rd_seen != $past(rd_seen)) || (y_q != $past(y_q))));

    // R7
    af_assert_cause_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $fell(af_n) |-> ($past(push) || (y_q != $past(y_q))));

endmodule

// File: tb/test_lf_level_flags.sv
module test_lf_level_flags;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int PX    = 2;
    localparam int PY    = 3;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic push = 1'b0, pop = 1'b0, x_ld = 1'b0, y_ld = 1'b0;
    logic [AW-1:0] x_val = '0, y_val = '0;
    logic af_n, ae_n;

    int checks = 0, fails = 0;
    bit chk_on = 1'b0, done = 1'b0;

    // Bench model: unbounded counts and a two-edge delayed view of the other side.
    int wr_cnt, rd_cnt, m1, m2, n1, n2, ex, ey;

    lf_level_flags #(.DEPTH(DEPTH), .PRESET_X(PX), .PRESET_Y(PY)) i_lf_level_flags (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .push(push), .y_ld(y_ld), .y_val(y_val),
        .af_n(af_n),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .pop(pop), .x_ld(x_ld), .x_val(x_val),
        .ae_n(ae_n)
    );

    // 100 MHz write clock; read clock 14 ns, phased so edges never coincide.
    always #5 wr_clk = ~wr_clk;
    initial begin
        #1;
        forever #7 rd_clk = ~rd_clk;
    end

    always @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wr_cnt <= 0; n1 <= 0; n2 <= 0; ey <= PY;
        end else begin
            if (push) wr_cnt <= wr_cnt + 1;
            n1 <= rd_cnt; n2 <= n1;
            if (y_ld) ey <= int'(y_val);
        end
    end

    always @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_cnt <= 0; m1 <= 0; m2 <= 0; ex <= PX;
        end else begin
            if (pop) rd_cnt <= rd_cnt + 1;
            m1 <= wr_cnt; m2 <= m1;
            if (x_ld) ex <= int'(x_val);
        end
    end

    function automatic logic exp_ae(int wseen, int rcnt, int x);
        return ((wseen - rcnt) > x);
    endfunction

    function automatic logic exp_af(int wcnt, int rseen, int y);
        return ((wcnt - rseen) < (DEPTH - y));
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Continuous model comparison (R2, R3; R9 once the counts have wrapped).
    always @(negedge rd_clk) begin
        if (chk_on) check((rd_cnt >= 2*DEPTH) ? "R9 ae_n" : "R2 ae_n", ae_n, exp_ae(m2, rd_cnt, ex));
    end
    always @(negedge wr_clk) begin
        if (chk_on) check((wr_cnt >= 2*DEPTH) ? "R9 af_n" : "R3 af_n", af_n, exp_af(wr_cnt, n2, ey));
    end

    task automatic do_push();
        @(negedge wr_clk); push = 1'b1;
        @(posedge wr_clk); push <= 1'b0;
    endtask

    task automatic do_pop();
        @(negedge rd_clk); pop = 1'b1;
        @(posedge rd_clk); pop <= 1'b0;
    endtask

    task automatic ld_x(int v);
        @(negedge rd_clk); x_ld = 1'b1; x_val = AW'(v);
        @(negedge rd_clk); x_ld = 1'b0;
    endtask

    task automatic ld_y(int v);
        @(negedge wr_clk); y_ld = 1'b1; y_val = AW'(v);
        @(negedge wr_clk); y_ld = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge rd_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        chk_on = 1'b1;

        // R1: reset state of both flags
        @(negedge rd_clk);
        check("R1 ae_n after reset", ae_n, 1'b0);
        check("R1 af_n after reset", af_n, 1'b1);

        // R1: preset X=2, level 3 -> ae_n high
        repeat (3) do_push();
        repeat (3) @(negedge rd_clk);
        check("R1 preset X", ae_n, 1'b1);

        // R8: load X=3 at level 3 -> ae_n low after the load edge
        ld_x(3);
        check("R8 X load", ae_n, 1'b0);

        // R4: 4th write, release only on the second read edge
        do_push();
        @(posedge rd_clk); @(negedge rd_clk);
        check("R4 first rd edge", ae_n, 1'b0);
        @(posedge rd_clk); @(negedge rd_clk);
        check("R4 second rd edge", ae_n, 1'b1);

        // R6: pop back to level 3 -> ae_n low right after that edge
        do_pop();
        @(negedge rd_clk);
        check("R6 pop into region", ae_n, 1'b0);

        // R8 on Y: load Y=4, boundary 12
        ld_y(4);
        repeat (8) do_push();
        @(negedge wr_clk);
        check("R3 level 11 below boundary", af_n, 1'b1);

        // R7: push to level 12 -> af_n low right after that edge
        do_push();
        @(negedge wr_clk);
        check("R7 push into region", af_n, 1'b0);

        // R5: pop to level 11, release on the second write edge
        do_pop();
        @(posedge wr_clk); @(negedge wr_clk);
        check("R5 first wr edge", af_n, 1'b0);
        @(posedge wr_clk); @(negedge wr_clk);
        check("R5 second wr edge", af_n, 1'b1);

        // R9: random fill/drain phases with random offset loads, many wraps
        fork
            for (int i = 0; i < 4000; i++) begin
                @(negedge wr_clk);
                push  = ((wr_cnt - n2) < DEPTH) && (($urandom % 100) < (((i / 400) % 2 == 0) ? 80 : 25));
                y_ld  = (($urandom % 150) == 0);
                y_val = AW'($urandom);
            end
            for (int j = 0; j < 2860; j++) begin
                @(negedge rd_clk);
                pop   = ((m2 - rd_cnt) > 0) && (($urandom % 100) < (((j / 286) % 2 == 0) ? 25 : 80));
                x_ld  = (($urandom % 150) == 0);
                x_val = AW'($urandom);
            end
        join
        @(negedge wr_clk); push = 1'b0; y_ld = 1'b0;
        @(negedge rd_clk); pop = 1'b0; x_ld = 1'b0;
        repeat (4) @(negedge wr_clk);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule